// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style microcontroller core. Each cycle it takes the working register, the value read from the file-register bus, an instruction literal and a three-bit bit index. Already-decoded control fields pick the two operands, the arithmetic mode, the logic function and which path drives the result. It returns an 8-bit result, combinational zero, digit-carry and carry indications, and two write strobes that send the result either to the working register or to the file register.

Clear, bit set, bit clear, increment and decrement have no dedicated hardware. They run through shared operand paths: a nibble-swapped copy of the file bus, a one-hot bit mask that can be inverted, and a constant one on the B side. The block also holds a three-flag status register. The stored carry feeds the rotates, and a flag is stored only when its own write enable is set. Decoding control fields from opcodes, sequencing and skip decisions are left to the surrounding core.

Top module: `acc_alu8`

## Requirements
- R1: The A operand follows `a_sel`: 0 gives `w_in`, 1 gives `fbus_in`, 2 gives `lit_in`, and 3 gives `fbus_in` with its upper and lower nibbles exchanged.
- R2: The B operand follows `b_sel`: 0 gives `w_in`, 1 gives `fbus_in`, 2 gives the bit mask, and 3 gives the constant 0x01.
- R3: The bit mask has only bit `bit_idx` set. When `bit_inv` is 1 the whole mask is inverted, so an AND with it clears that bit of A and an OR with the uninverted mask sets it.
- R4: With `res_sel` = 1 the result is the logic path, chosen by `logic_op`: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, and 3 gives NOT A.
- R5: With `res_sel` = 0 the result is the arithmetic path, chosen by `arith_mode`. 2 gives A+B. 3 gives A−B, computed as A plus the two's complement of B. Modes 0 and 1 pass A unchanged. Carry is the carry out of bit 7, which for subtraction means 1 when no borrow occurs. Digit carry is the carry out of bit 3 under the same rule. Both are 0 in the pass modes.
- R6: `res_sel` = 2 rotates A right, with the stored carry entering bit 7 and bit 0 leaving as `c_out`. `res_sel` = 3 rotates A left, with the stored carry entering bit 0 and bit 7 leaving as `c_out`.
- R7: `z_out` is 1 exactly when `result` equals 0x00.
- R8: A synchronous active-low reset clears all three stored flags. On a clock edge with `rst_n` high, a stored flag whose write enable is 1 takes the value of its combinational output.
- R9: When `wr_req` is 1, `dest_file` = 0 raises only `w_wr` and `dest_file` = 1 raises only `f_wr`. When `wr_req` is 0 neither strobe rises.
- R10: A stored flag whose write enable is 0 keeps its value. For logic results and rotates, `dc_out` repeats the stored digit carry. For logic results, `c_out` repeats the stored carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| w_in | input | 8 | Working register value |
| fbus_in | input | 8 | File-register read data |
| lit_in | input | 8 | Instruction literal |
| bit_idx | input | 3 | Bit number for the bit mask |
| a_sel | input | 2 | A operand select |
| b_sel | input | 2 | B operand select |
| arith_mode | input | 2 | Pass / add / subtract |
| logic_op | input | 2 | Logic function |
| res_sel | input | 2 | Result path select |
| bit_inv | input | 1 | Invert the bit mask |
| dest_file | input | 1 | Destination: 0 working register, 1 file |
| wr_req | input | 1 | Result is to be written |
| z_we | input | 1 | Store zero flag |
| dc_we | input | 1 | Store digit-carry flag |
| c_we | input | 1 | Store carry flag |
| result | output | 8 | ALU result |
| z_out | output | 1 | Zero indication |
| dc_out | output | 1 | Digit-carry indication |
| c_out | output | 1 | Carry indication |
| w_wr | output | 1 | Write strobe for the working register |
| f_wr | output | 1 | Write strobe for the file register |
| stat_z | output | 1 | Stored zero flag |
| stat_dc | output | 1 | Stored digit carry |
| stat_c | output | 1 | Stored carry |

## Verification
The hardest case to reach is a rotate whose incoming bit is a 1. The rotate reads the stored carry, and no input sets that directly. The stimulus first runs an addition that overflows with the carry write enable set, so the flag is loaded. The rotate on the following cycle must then show that bit at the opposite end of the byte. Other sequences store a flag and then run operations with that enable off, to show the stored value survives several cycles of unrelated results.

// File: rtl/alu8_pkg.sv
// Shared encodings for the accumulator ALU.
// Assumes every control field is two bits wide and already decoded.
package alu8_pkg;

    typedef enum logic [1:0] {
        A_WREG = 2'b00,
        A_FILE = 2'b01,
        A_LIT  = 2'b10,
        A_SWAP = 2'b11
    } asel_e;

    typedef enum logic [1:0] {
        B_WREG   = 2'b00,
        B_FILE   = 2'b01,
        B_BITDEC = 2'b10,
        B_ONE    = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        AR_PASS  = 2'b00,
        AR_PASS1 = 2'b01,
        AR_ADD   = 2'b10,
        AR_SUB   = 2'b11
    } arith_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_OR   = 2'b01,
        LG_XOR  = 2'b10,
        LG_NOTA = 2'b11
    } logic_e;

    typedef enum logic [1:0] {
        RS_ARITH = 2'b00,
        RS_LOGIC = 2'b01,
        RS_ROR   = 2'b10,
        RS_ROL   = 2'b11
    } rsel_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_opmux.sv
// Operand selection for the ALU.
// Builds the A operand (working reg, file bus, literal, nibble-swapped bus)
// and the B operand (working reg, file bus, one-hot bit mask, constant one).
// Assumes DW is even and a power of two, so the bit index covers every bit.
module alu8_opmux
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]         w_in,
    input  logic [DW-1:0]         fbus_in,
    input  logic [DW-1:0]         lit_in,
    input  logic [$clog2(DW)-1:0] bit_idx,
    input  asel_e                 a_sel,
    input  bsel_e                 b_sel,
    input  logic                  bit_inv,
    output logic [DW-1:0]         a_opnd,
    output logic [DW-1:0]         b_opnd
);
    localparam int IW  = $clog2(DW);
    localparam int NIB = DW / 2;

    logic [DW-1:0] onehot;
    logic [DW-1:0] mask;
    logic [DW-1:0] swapped;

    // One comparator per bit forms the one-hot mask.
    for (genvar i = 0; i < DW; i++) begin : g_dec
        assign onehot[i] = (bit_idx == IW'(i));
    end

    assign mask    = bit_inv ? ~onehot : onehot;
    assign swapped = {fbus_in[NIB-1:0], fbus_in[DW-1:NIB]};

    // Pick the A operand.
    always_comb begin
        unique case (a_sel)
            A_WREG:  a_opnd = w_in;
            A_FILE:  a_opnd = fbus_in;
            A_LIT:   a_opnd = lit_in;
            default: a_opnd = swapped;
        endcase
    end

    // Pick the B operand.
    always_comb begin
        unique case (b_sel)
            B_WREG:   b_opnd = w_in;
            B_FILE:   b_opnd = fbus_in;
            B_BITDEC: b_opnd = mask;
            default:  b_opnd = DW'(1);
        endcase
    end
endmodule

// File: rtl/alu8_arith.sv
// Adder/subtractor with carry and half-word (digit) carry.
// Subtraction is A + ~B + 1, so carry = 1 means no borrow.
// Assumes DW is even; the digit carry comes out of the low half.
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  arith_e        mode,
    output logic [DW-1:0] sum,
    output logic          dc,
    output logic          c
);
    localparam int NIB = DW / 2;

    logic          is_sub;
    logic [DW-1:0] b_adj;
    logic [DW:0]   full;
    logic [NIB:0]  low;

    // Shared adder with optional inversion of B and a carry-in of one.
    always_comb begin
        is_sub = (mode == AR_SUB);
        b_adj  = is_sub ? ~b : b;
        full   = {1'b0, a} + {1'b0, b_adj} + {{DW{1'b0}}, is_sub};
        low    = {1'b0, a[NIB-1:0]} + {1'b0, b_adj[NIB-1:0]} + {{NIB{1'b0}}, is_sub};
    end

    // Drive the outputs for add/sub, or pass A with cleared carries.
    always_comb begin
        if (mode == AR_ADD || mode == AR_SUB) begin
            sum = full[DW-1:0];
            c   = full[DW];
            dc  = low[NIB];
        end else begin
            sum = a;
            c   = 1'b0;
            dc  = 1'b0;
        end
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise logic unit: AND, OR, XOR, or complement of A.
// Assumes both operands are already selected.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic_e        op,
    output logic [DW-1:0] y
);
    // Apply the chosen bitwise function.
    always_comb begin
        unique case (op)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
// Three-flag status register with one write enable per flag.
// Assumes a synchronous active-low reset that clears every flag.
module alu8_status
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t nxt,
    input  flags_t we,
    output flags_t q
);
    // Store each flag only when its own enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we.z)  q.z  <= nxt.z;
            if (we.dc) q.dc <= nxt.dc;
            if (we.c)  q.c  <= nxt.c;
        end
    end

    // R10
    z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we.z |=> $stable(q.z));
    // R10
    c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we.c |=> $stable(q.c));
    // R8
    dc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we.dc |=> (q.dc == $past(nxt.dc)));
endmodule

// File: rtl/acc_alu8.sv
// Top of the accumulator ALU.
// Joins the operand muxes, the adder, the logic unit, the rotates through
// the stored carry, the result and flag selection, destination steering
// and the status register.
// Assumes the control fields are stable for the whole cycle.
module acc_alu8
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         w_in,
    input  logic [DW-1:0]         fbus_in,
    input  logic [DW-1:0]         lit_in,
    input  logic [$clog2(DW)-1:0] bit_idx,
    input  logic [1:0]            a_sel,
    input  logic [1:0]            b_sel,
    input  logic [1:0]            arith_mode,
    input  logic [1:0]            logic_op,
    input  logic [1:0]            res_sel,
    input  logic                  bit_inv,
    input  logic                  dest_file,
    input  logic                  wr_req,
    input  logic                  z_we,
    input  logic                  dc_we,
    input  logic                  c_we,
    output logic [DW-1:0]         result,
    output logic                  z_out,
    output logic                  dc_out,
    output logic                  c_out,
    output logic                  w_wr,
    output logic                  f_wr,
    output logic                  stat_z,
    output logic                  stat_dc,
    output logic                  stat_c
);
    logic [DW-1:0] a_opnd;
    logic [DW-1:0] b_opnd;
    logic [DW-1:0] ar_sum;
    logic          ar_dc;
    logic          ar_c;
    logic [DW-1:0] lg_y;
    flags_t        st_q;
    flags_t        st_nxt;
    flags_t        st_we;
    rsel_e         rsel;

    assign rsel = rsel_e'(res_sel);

    alu8_opmux #(.DW(DW)) u_opmux (
        .w_in    (w_in),
        .fbus_in (fbus_in),
        .lit_in  (lit_in),
        .bit_idx (bit_idx),
        .a_sel   (asel_e'(a_sel)),
        .b_sel   (bsel_e'(b_sel)),
        .bit_inv (bit_inv),
        .a_opnd  (a_opnd),
        .b_opnd  (b_opnd)
    );

    alu8_arith #(.DW(DW)) u_arith (
        .a    (a_opnd),
        .b    (b_opnd),
        .mode (arith_e'(arith_mode)),
        .sum  (ar_sum),
        .dc   (ar_dc),
        .c    (ar_c)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .a  (a_opnd),
        .b  (b_opnd),
        .op (logic_e'(logic_op)),
        .y  (lg_y)
    );

    // Choose the result path and the carries that go with it.
    always_comb begin
        dc_out = st_q.dc;
        c_out  = st_q.c;
        unique case (rsel)
            RS_ARITH: begin
                result = ar_sum;
                dc_out = ar_dc;
                c_out  = ar_c;
            end
            RS_LOGIC: result = lg_y;
            RS_ROR: begin
                result = {st_q.c, a_opnd[DW-1:1]};
                c_out  = a_opnd[0];
            end
            default: begin
                result = {a_opnd[DW-2:0], st_q.c};
                c_out  = a_opnd[DW-1];
            end
        endcase
    end

    assign z_out = ~|result;

    // Steer the write strobe to one destination.
    always_comb begin
        w_wr = wr_req & ~dest_file;
        f_wr = wr_req &  dest_file;
    end

    assign st_nxt = '{z: z_out, dc: dc_out, c: c_out};
    assign st_we  = '{z: z_we, dc: dc_we, c: c_we};

    alu8_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (st_nxt),
        .we    (st_we),
        .q     (st_q)
    );

    assign stat_z  = st_q.z;
    assign stat_dc = st_q.dc;
    assign stat_c  = st_q.c;

    // R9
    dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({w_wr, f_wr}) && (wr_req == (w_wr | f_wr)));
    // R3
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel == 2'b10 && !bit_inv) |-> ($countones(b_opnd) == 1));
    // R5
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == RS_ARITH && arith_mode == 2'b11) |-> (c_out == (a_opnd >= b_opnd)));
    // R6
    ror_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == RS_ROR) |-> (result[DW-1] == stat_c && c_out == a_opnd[0]));
    // R7
    xor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == RS_LOGIC && logic_op == 2'b10 && a_opnd == b_opnd) |-> z_out);
endmodule

// File: tb/test_acc_alu8.sv
module test_acc_alu8;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] w_in = '0, fbus_in = '0, lit_in = '0;
    logic [2:0] bit_idx = '0;
    logic [1:0] a_sel = '0, b_sel = '0, arith_mode = '0, logic_op = '0, res_sel = '0;
    logic       bit_inv = 0, dest_file = 0, wr_req = 0, z_we = 0, dc_we = 0, c_we = 0;
    logic [7:0] result;
    logic       z_out, dc_out, c_out, w_wr, f_wr, stat_z, stat_dc, stat_c;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [16:0] v;   // {result, z, dc, c, w_wr, f_wr, stat_z, stat_dc, stat_c}
        string       req;
    } item_t;
    item_t sb[$];
    event  drove;

    logic m_z = 0, m_dc = 0, m_c = 0;

    acc_alu8 i_acc_alu8 (
        .clk, .rst_n, .w_in, .fbus_in, .lit_in, .bit_idx, .a_sel, .b_sel,
        .arith_mode, .logic_op, .res_sel, .bit_inv, .dest_file, .wr_req,
        .z_we, .dc_we, .c_we, .result, .z_out, .dc_out, .c_out, .w_wr, .f_wr,
        .stat_z, .stat_dc, .stat_c
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic op(input logic [1:0] as, bs, am, lo, rs,
                      input logic inv, dst, wr, zw, dw, cw,
                      input logic [7:0] wv, fv, kv, input logic [2:0] ix,
                      input string req);
        logic [7:0] a, b, dec, s, lg, res;
        logic [8:0] s9;
        logic [4:0] s5;
        logic ec, edc, ez, ac, adc;
        item_t it;
        case (as)
            2'd0: a = wv;
            2'd1: a = fv;
            2'd2: a = kv;
            default: a = {fv[3:0], fv[7:4]};
        endcase
        dec = 8'd1 << ix;
        if (inv) dec = ~dec;
        case (bs)
            2'd0: b = wv;
            2'd1: b = fv;
            2'd2: b = dec;
            default: b = 8'd1;
        endcase
        if (am == 2'd2) begin
            s9 = {1'b0, a} + {1'b0, b}; s = s9[7:0]; ac = s9[8];
            s5 = {1'b0, a[3:0]} + {1'b0, b[3:0]}; adc = s5[4];
        end else if (am == 2'd3) begin
            s = a - b; ac = (a >= b); adc = (a[3:0] >= b[3:0]);
        end else begin
            s = a; ac = 0; adc = 0;
        end
        case (lo)
            2'd0: lg = a & b;
            2'd1: lg = a | b;
            2'd2: lg = a ^ b;
            default: lg = ~a;
        endcase
        edc = m_dc; ec = m_c;
        case (rs)
            2'd0: begin res = s; ec = ac; edc = adc; end
            2'd1: res = lg;
            2'd2: begin res = {m_c, a[7:1]}; ec = a[0]; end
            default: begin res = {a[6:0], m_c}; ec = a[7]; end
        endcase
        ez = (res == 8'h00);
        @(negedge clk);
        a_sel = as; b_sel = bs; arith_mode = am; logic_op = lo; res_sel = rs;
        bit_inv = inv; dest_file = dst; wr_req = wr; z_we = zw; dc_we = dw; c_we = cw;
        w_in = wv; fbus_in = fv; lit_in = kv; bit_idx = ix;
        it.v = {res, ez, edc, ec, wr & ~dst, wr & dst, m_z, m_dc, m_c};
        it.req = req;
        sb.push_back(it);
        -> drove;
        if (zw) m_z = ez;
        if (dw) m_dc = edc;
        if (cw) m_c = ec;
    endtask

    // Monitor: compare each driven cycle against the queued expectation.
    initial begin
        forever begin
            @(drove);
            #1;
            if (sb.size() != 0) begin
                item_t it;
                logic [16:0] act;
                it = sb.pop_front();
                act = {result, z_out, dc_out, c_out, w_wr, f_wr, stat_z, stat_dc, stat_c};
                checks++;
                if (act !== it.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.v);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        checks++;
        if ({stat_z, stat_dc, stat_c} !== 3'b000) begin
            errors++;
            $display("FAIL R8 actual=%b expected=000", {stat_z, stat_dc, stat_c});
        end
        //  as    bs    am    lo    rs   inv dst wr zw dw cw  w      f      k     ix
        // R1 operand A selections through pass mode
        op(2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'h71, 3'd0, "R1");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'h71, 3'd0, "R1");
        op(2'd2, 2'd0, 2'd1, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'h71, 3'd0, "R1");
        op(2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'h71, 3'd0, "R1");
        // R2 operand B selections
        op(2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'hFF, 3'd0, "R2");
        op(2'd2, 2'd1, 2'd0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'hFF, 3'd0, "R2");
        op(2'd2, 2'd3, 2'd2, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h3C, 8'hA5, 8'h41, 3'd0, "R2");
        // R3 bit mask: set, clear, every index
        op(2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00, 8'h00, 3'd7, "R3");
        op(2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 1, 1, 1, 0, 0, 0, 8'h00, 8'hFF, 8'h00, 3'd5, "R3");
        for (int i = 0; i < 8; i++)
            op(2'd2, 2'd2, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 3'(i), "R3");
        // R4 logic functions
        op(2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 0, 0, 0, 1, 0, 0, 8'hF0, 8'h3C, 8'h00, 3'd0, "R4");
        op(2'd0, 2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0, 1, 0, 0, 8'hF0, 8'h3C, 8'h00, 3'd0, "R4");
        op(2'd0, 2'd1, 2'd0, 2'd2, 2'd1, 0, 0, 0, 1, 0, 0, 8'hF0, 8'h3C, 8'h00, 3'd0, "R4");
        op(2'd0, 2'd1, 2'd0, 2'd3, 2'd1, 0, 0, 0, 1, 0, 0, 8'hF0, 8'h3C, 8'h00, 3'd0, "R4");
        // R5 add/sub corners, all flags stored
        op(2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0, 1, 1, 1, 1, 8'h0F, 8'h01, 8'h00, 3'd0, "R5");
        op(2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0, 1, 1, 1, 1, 8'hFF, 8'h01, 8'h00, 3'd0, "R5");
        op(2'd1, 2'd0, 2'd3, 2'd0, 2'd0, 0, 1, 1, 1, 1, 1, 8'h05, 8'h05, 8'h00, 3'd0, "R5");
        op(2'd1, 2'd0, 2'd3, 2'd0, 2'd0, 0, 1, 1, 1, 1, 1, 8'h05, 8'h03, 8'h00, 3'd0, "R5");
        op(2'd1, 2'd3, 2'd3, 2'd0, 2'd0, 0, 1, 1, 1, 1, 1, 8'h00, 8'h10, 8'h00, 3'd0, "R5");
        op(2'd1, 2'd3, 2'd3, 2'd0, 2'd0, 0, 1, 1, 1, 0, 0, 8'h00, 8'h00, 8'h00, 3'd0, "R5");
        // R6 load carry with an overflowing add, then rotate
        op(2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0, 0, 0, 0, 1, 8'h80, 8'h80, 8'h00, 3'd0, "R6");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 0, 1, 1, 0, 0, 1, 8'h00, 8'h02, 8'h00, 3'd0, "R6");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 0, 1, 1, 0, 0, 1, 8'h00, 8'h01, 8'h00, 3'd0, "R6");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 0, 1, 1, 0, 0, 1, 8'h00, 8'h80, 8'h00, 3'd0, "R6");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 0, 1, 1, 0, 0, 1, 8'h00, 8'h40, 8'h00, 3'd0, "R6");
        // R7 zero from xor of equal values and from clear
        op(2'd0, 2'd1, 2'd0, 2'd2, 2'd1, 0, 0, 1, 1, 0, 0, 8'h5A, 8'h5A, 8'h00, 3'd0, "R7");
        op(2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 0, 1, 1, 1, 0, 0, 8'h77, 8'h00, 8'h00, 3'd0, "R7");
        op(2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00, 8'h01, 3'd0, "R7");
        // R9 destination steering
        op(2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 1, 0, 0, 0, 8'h00, 8'h00, 8'h12, 3'd0, "R9");
        op(2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00, 8'h12, 3'd0, "R9");
        op(2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00, 8'h12, 3'd0, "R9");
        // R10 set all flags, then run flag-changing results with enables off
        op(2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0, 0, 1, 1, 1, 8'hFF, 8'h01, 8'h00, 3'd0, "R10");
        op(2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 8'h01, 8'h01, 8'h00, 3'd0, "R10");
        op(2'd0, 2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0, 8'h01, 8'h02, 8'h00, 3'd0, "R10");
        op(2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0, 8'h00, 8'h02, 8'h00, 3'd0, "R10");
        // R8 mixed operations with random enables
        for (int i = 0; i < 60; i++)
            op(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), "R8");
        op(2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 3'd0, "R8");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule